// File: doc/BRIEF.md
# Guarded Flash-Programming Control Register

This unit holds the control bits that steer in-system reprogramming of on-chip flash. The control register is write-protected. Software opens it by writing two key bytes, 87h and then 59h, to a separate key register. Any other key write closes it again. Once the register is open, software can set three fields: programming enable, boot/destination bank select, and auxiliary-RAM enable.

One write combination turns the register into a software-reset command. The unit then emits a one-cycle reset request and returns itself to its reset state. While the part is running from the loader bank (the boot-from-loader status input), that reset command is disabled and the status shows up in the top bit of the read value.

When programming enable is held and the idle state is left through an interrupt, the unit raises an ISP-active flag. The flag holds until programming enable is cleared or a software reset occurs. The unit sits on a simple byte-wide SFR write bus. The flash array and its timing belong to other logic.

Top module: `isp_ctrl_unit`

## Requirements
- R1: After synchronous reset, `prog_en`, `boot_sel`, `aux_ram_en`, `isp_active` and `swrst_req` are 0, the key register is locked, and `ctl_rdata` is {`loader_boot`, 7'b0}.
- R2: A write to `CTL_ADDR` changes no field unless the key register is open. Writes to any address other than `KEY_ADDR` or `CTL_ADDR` change neither the fields nor the key state.
- R3: A key write of any value other than 87h or 59h locks the key register. A 59h key write that does not directly follow an 87h key write also locks it.
- R4: The key register opens only when an 87h key write is directly followed by a 59h key write. An 87h followed by any other key write relocks it. An 87h key write always restarts the sequence. The register stays open across control writes.
- R5: On an accepted control write, `wdata[0]` goes to `prog_en`, `wdata[1]` to `boot_sel` and `wdata[4]` to `aux_ram_en`. The read value places these fields at the same bit positions. Bits 6:5 and 3:2 always read 0, and writes to them are dropped.
- R6: `ctl_rdata[7]` always equals `loader_boot`, in the same cycle.
- R7: An accepted control write with bits 7, 1 and 0 all set, while `loader_boot` is 0, has the following effects in the next cycle:
  - `swrst_req` pulses for exactly one cycle;
  - all fields and `isp_active` are 0;
  - the key register is locked.
- R8: While `loader_boot` is 1, the reset combination produces no `swrst_req`; the write is stored as an ordinary control write.
- R9: `isp_active` rises in the cycle after a `wake_irq` cycle in which `prog_en` was already 1. A wake while `prog_en` is 0 has no effect.
- R10: `isp_active` falls in the cycle after a write that clears `prog_en`, or with a software reset. A software reset wins over a wake in the same cycle.
- R11: A wake that coincides with a control write is judged against the `prog_en` held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_wr | input | 1 | Write strobe of the SFR bus |
| sfr_addr | input | ADDR_W | SFR write address |
| sfr_wdata | input | 8 | SFR write data |
| wake_irq | input | 1 | One-cycle pulse: idle left through an interrupt |
| loader_boot | input | 1 | Part is running in boot-from-loader mode |
| ctl_rdata | output | 8 | Read view of the control register |
| prog_en | output | 1 | Programming enable field |
| boot_sel | output | 1 | Boot/destination bank select field |
| aux_ram_en | output | 1 | Auxiliary-RAM enable field |
| swrst_req | output | 1 | One-cycle software-reset request |
| isp_active | output | 1 | Programming mode entered |

## Verification
Two functions can land in the same cycle.

The first pair is an interrupt wake and a control write. The bench drives the wake together with a write that sets `prog_en` (the flag must stay low) and again with a write that keeps it set (the flag must rise). This judges whether the wake reads the old or the new field value.

The second pair is a wake and the software-reset write. The reset must win and leave `isp_active` low.

A behavioural reference model runs beside the design and compares every output on every clock.

// File: rtl/isp_ctrl_pkg.sv
package isp_ctrl_pkg;

    localparam int DATA_W    = 8;
    localparam int BIT_PROG  = 0;
    localparam int BIT_BANK  = 1;
    localparam int BIT_AUX   = 4;
    localparam int BIT_SWRST = 7;

    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_HALF   = 2'd1,
        KS_OPEN   = 2'd2
    } key_state_e;

    typedef struct packed {
        logic aux;
        logic bank;
        logic prog;
    } ctl_fields_t;

    function automatic logic is_reset_combo(input logic [DATA_W-1:0] d);
        return d[BIT_SWRST] & d[BIT_BANK] & d[BIT_PROG];
    endfunction

    function automatic ctl_fields_t fields_from(input logic [DATA_W-1:0] d);
        ctl_fields_t f;
        f.aux  = d[BIT_AUX];
        f.bank = d[BIT_BANK];
        f.prog = d[BIT_PROG];
        return f;
    endfunction

    function automatic logic [DATA_W-1:0] read_view(input ctl_fields_t f, input logic ldr);
        logic [DATA_W-1:0] v;
        v            = '0;
        v[BIT_PROG]  = f.prog;
        v[BIT_BANK]  = f.bank;
        v[BIT_AUX]   = f.aux;
        v[BIT_SWRST] = ldr;
        return v;
    endfunction

endpackage

// File: rtl/isp_key_seq.sv
module isp_key_seq
    import isp_ctrl_pkg::*;
#(
    parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h87,
    parameter logic [DATA_W-1:0] KEY_SECOND = 8'h59
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_data,
    input  logic              clear,
    output logic              unlocked
);
    key_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (clear) begin
            state_d = KS_LOCKED;
        end else if (key_wr) begin
            if (key_data == KEY_FIRST)
                state_d = KS_HALF;
            else if (key_data == KEY_SECOND && state_q == KS_HALF)
                state_d = KS_OPEN;
            else
                state_d = KS_LOCKED;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= KS_LOCKED;
        else     state_q <= state_d;
    end

    assign unlocked = (state_q == KS_OPEN);
endmodule

// File: rtl/isp_ctl_bits.sv
module isp_ctl_bits
    import isp_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              loader_boot,
    output ctl_fields_t       fields,
    output logic              swrst_req,
    output logic              swrst_fire,
    output logic              prog_next
);
    ctl_fields_t q, d;

    always_comb begin
        swrst_fire = ctl_wr && is_reset_combo(wdata) && !loader_boot;
        d = q;
        if (swrst_fire)  d = '0;
        else if (ctl_wr) d = fields_from(wdata);
        prog_next = d.prog;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q         <= '0;
            swrst_req <= 1'b0;
        end else begin
            q         <= d;
            swrst_req <= swrst_fire;
        end
    end

    assign fields = q;
endmodule

// File: rtl/isp_wake_track.sv
module isp_wake_track (
    input  logic clk,
    input  logic rst,
    input  logic wake_irq,
    input  logic prog_now,
    input  logic prog_next,
    input  logic swrst_fire,
    output logic active
);
    logic active_q;

    always_ff @(posedge clk) begin
        if (rst)                        active_q <= 1'b0;
        else if (swrst_fire || !prog_next) active_q <= 1'b0;
        else if (wake_irq && prog_now)  active_q <= 1'b1;
    end

    assign active = active_q;
endmodule

// File: rtl/isp_ctrl_unit.sv
module isp_ctrl_unit
    import isp_ctrl_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'hF6,
    parameter logic [ADDR_W-1:0] CTL_ADDR   = 8'hBF,
    parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h87,
    parameter logic [DATA_W-1:0] KEY_SECOND = 8'h59
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sfr_wr,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic [DATA_W-1:0] sfr_wdata,
    input  logic              wake_irq,
    input  logic              loader_boot,
    output logic [DATA_W-1:0] ctl_rdata,
    output logic              prog_en,
    output logic              boot_sel,
    output logic              aux_ram_en,
    output logic              swrst_req,
    output logic              isp_active
);
    logic        key_hit, ctl_hit, unlocked, swrst_fire, prog_next;
    ctl_fields_t fields;

    assign key_hit = sfr_wr && (sfr_addr == KEY_ADDR);
    assign ctl_hit = sfr_wr && (sfr_addr == CTL_ADDR);

    isp_key_seq #(.KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)) u_key (
        .clk(clk), .rst(rst), .key_wr(key_hit), .key_data(sfr_wdata),
        .clear(swrst_fire), .unlocked(unlocked)
    );

    isp_ctl_bits u_bits (
        .clk(clk), .rst(rst), .ctl_wr(ctl_hit && unlocked), .wdata(sfr_wdata),
        .loader_boot(loader_boot), .fields(fields), .swrst_req(swrst_req),
        .swrst_fire(swrst_fire), .prog_next(prog_next)
    );

    isp_wake_track u_wake (
        .clk(clk), .rst(rst), .wake_irq(wake_irq), .prog_now(fields.prog),
        .prog_next(prog_next), .swrst_fire(swrst_fire), .active(isp_active)
    );

    assign prog_en    = fields.prog;
    assign boot_sel   = fields.bank;
    assign aux_ram_en = fields.aux;
    assign ctl_rdata  = read_view(fields, loader_boot);
endmodule

// File: rtl/isp_ctrl_unit_chk.sv
module isp_ctrl_unit_chk #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 8'hBF
) (
    input logic              clk,
    input logic              rst,
    input logic              sfr_wr,
    input logic [ADDR_W-1:0] sfr_addr,
    input logic              wake_irq,
    input logic              loader_boot,
    input logic              prog_en,
    input logic              boot_sel,
    input logic              aux_ram_en,
    input logic              swrst_req,
    input logic              isp_active
);
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        swrst_req |=> !swrst_req);

    a_r7_clears_all: assert property (@(posedge clk) disable iff (rst)
        swrst_req |-> (!prog_en && !boot_sel && !aux_ram_en && !isp_active));

    a_r8_no_reset_in_loader: assert property (@(posedge clk) disable iff (rst)
        swrst_req |-> !$past(loader_boot));

    a_r2_fields_need_write: assert property (@(posedge clk) disable iff (rst)
        !$stable({prog_en, boot_sel, aux_ram_en}) |-> $past(sfr_wr && sfr_addr == CTL_ADDR));

    a_r9_rise_after_wake: assert property (@(posedge clk) disable iff (rst)
        $rose(isp_active) |-> ($past(wake_irq) && $past(prog_en)));

    a_r10_active_needs_prog: assert property (@(posedge clk) disable iff (rst)
        isp_active |-> prog_en);
endmodule

bind isp_ctrl_unit isp_ctrl_unit_chk #(.ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR)) u_chk (
    .clk(clk), .rst(rst), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr), .wake_irq(wake_irq),
    .loader_boot(loader_boot), .prog_en(prog_en), .boot_sel(boot_sel),
    .aux_ram_en(aux_ram_en), .swrst_req(swrst_req), .isp_active(isp_active)
);

// File: tb/isp_ctrl_unit_tb.sv
`timescale 1ns/100ps
module isp_ctrl_unit_tb;
    localparam logic [7:0] KA = 8'hF6;
    localparam logic [7:0] CA = 8'hBF;

    logic       clk = 1'b0;
    logic       rst, sfr_wr, wake_irq, loader_boot;
    logic [7:0] sfr_addr, sfr_wdata, ctl_rdata;
    logic       prog_en, boot_sel, aux_ram_en, swrst_req, isp_active;

    int    n_chk = 0, n_fail = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    isp_ctrl_unit u_dut (
        .clk(clk), .rst(rst), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
        .sfr_wdata(sfr_wdata), .wake_irq(wake_irq), .loader_boot(loader_boot),
        .ctl_rdata(ctl_rdata), .prog_en(prog_en), .boot_sel(boot_sel),
        .aux_ram_en(aux_ram_en), .swrst_req(swrst_req), .isp_active(isp_active)
    );

    // behavioural reference model
    int m_key = 0;   // 0 locked, 1 first key seen, 2 open
    bit m_prog = 0, m_bank = 0, m_aux = 0, m_isp = 0, m_sw = 0;

    always @(posedge clk) begin
        bit old_prog;
        old_prog = m_prog;
        m_sw = 0;
        if (rst) begin
            m_key = 0; m_prog = 0; m_bank = 0; m_aux = 0; m_isp = 0;
        end else begin
            if (sfr_wr && sfr_addr == KA) begin
                if (sfr_wdata == 8'h87)                    m_key = 1;
                else if (sfr_wdata == 8'h59 && m_key == 1) m_key = 2;
                else                                       m_key = 0;
            end else if (sfr_wr && sfr_addr == CA && m_key == 2) begin
                if (sfr_wdata[7] && sfr_wdata[1] && sfr_wdata[0] && !loader_boot) begin
                    m_sw = 1; m_key = 0; m_prog = 0; m_bank = 0; m_aux = 0;
                end else begin
                    m_prog = sfr_wdata[0]; m_bank = sfr_wdata[1]; m_aux = sfr_wdata[4];
                end
            end
            if (m_sw || !m_prog)        m_isp = 0;
            else if (wake_irq && old_prog) m_isp = 1;
        end
    end

    always @(posedge clk) begin
        logic [7:0] exp_r;
        #1;
        exp_r = {loader_boot, 2'b00, m_aux, 2'b00, m_bank, m_prog};
        n_chk++;
        if (ctl_rdata !== exp_r || prog_en !== m_prog || boot_sel !== m_bank ||
            aux_ram_en !== m_aux || swrst_req !== m_sw || isp_active !== m_isp) begin
            n_fail++;
            $display("FAIL %s model: got rd=%h sw=%b isp=%b, exp rd=%h sw=%b isp=%b",
                     cur_req, ctl_rdata, swrst_req, isp_active, exp_r, m_sw, m_isp);
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic w, input logic [7:0] a, input logic [7:0] d, input logic wk);
        sfr_wr = w; sfr_addr = a; sfr_wdata = d; wake_irq = wk;
        @(negedge clk);
        sfr_wr = 0; wake_irq = 0;
    endtask

    task automatic unlock();
        step(1, KA, 8'h87, 0);
        step(1, KA, 8'h59, 0);
    endtask

    initial begin
        rst = 1; sfr_wr = 0; sfr_addr = 0; sfr_wdata = 0; wake_irq = 0; loader_boot = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        cur_req = "R1";
        chk("R1 rdata", ctl_rdata, 8'h00);
        chk("R1 flags", {6'b0, swrst_req, isp_active}, 8'h00);

        cur_req = "R2";
        step(1, CA, 8'hFF, 0);
        chk("R2 locked write", ctl_rdata, 8'h00);
        step(1, 8'h20, 8'h87, 0); step(1, 8'h20, 8'h59, 0); step(1, CA, 8'h13, 0);
        chk("R2 other address", ctl_rdata, 8'h00);

        cur_req = "R5";
        unlock(); step(1, CA, 8'h1F, 0);
        chk("R5 fields", ctl_rdata, 8'h13);
        step(1, CA, 8'h7D, 0);
        chk("R5 reserved dropped", ctl_rdata, 8'h11);

        cur_req = "R3";
        step(1, KA, 8'h33, 0); step(1, CA, 8'h02, 0);
        chk("R3 bad key", ctl_rdata, 8'h11);
        step(1, KA, 8'h59, 0); step(1, CA, 8'h02, 0);
        chk("R3 lone second key", ctl_rdata, 8'h11);

        cur_req = "R4";
        step(1, KA, 8'h87, 0); step(1, KA, 8'h12, 0); step(1, KA, 8'h59, 0);
        step(1, CA, 8'h02, 0);
        chk("R4 broken sequence", ctl_rdata, 8'h11);
        step(1, KA, 8'h87, 0); step(1, KA, 8'h87, 0); step(1, KA, 8'h59, 0);
        step(1, CA, 8'h10, 0);
        chk("R4 restart opens", ctl_rdata, 8'h10);

        cur_req = "R9";
        step(0, 0, 0, 1);
        chk("R9 wake without prog", {7'b0, isp_active}, 8'h00);
        step(1, CA, 8'h11, 0); step(0, 0, 0, 1);
        chk("R9 wake with prog", {7'b0, isp_active}, 8'h01);

        cur_req = "R10";
        step(1, CA, 8'h10, 0);
        chk("R10 prog cleared", {7'b0, isp_active}, 8'h00);

        cur_req = "R11";
        step(1, CA, 8'h01, 1);
        chk("R11 wake uses old prog 0", {7'b0, isp_active}, 8'h00);
        step(1, CA, 8'h01, 1);
        chk("R11 wake uses old prog 1", {7'b0, isp_active}, 8'h01);

        cur_req = "R7";
        step(1, CA, 8'h83, 0);
        chk("R7 pulse", {7'b0, swrst_req}, 8'h01);
        chk("R7 cleared", {ctl_rdata[6:0], isp_active}, 8'h00);
        step(0, 0, 0, 0);
        chk("R7 single cycle", {7'b0, swrst_req}, 8'h00);
        step(1, CA, 8'h01, 0);
        chk("R7 key relocked", ctl_rdata, 8'h00);

        cur_req = "R10";
        unlock(); step(1, CA, 8'h01, 0); step(0, 0, 0, 1);
        step(1, CA, 8'h83, 1);
        chk("R10 reset beats wake", {6'b0, swrst_req, isp_active}, 8'h02);
        step(0, 0, 0, 0);

        cur_req = "R6";
        loader_boot = 1; #0.5;
        chk("R6 bit7 follows status", ctl_rdata, 8'h80);
        cur_req = "R8";
        unlock(); step(1, CA, 8'h83, 0);
        chk("R8 no reset in loader", {7'b0, swrst_req}, 8'h00);
        chk("R8 stored as write", ctl_rdata, 8'h83);
        step(0, 0, 0, 0);
        loader_boot = 0; #0.5;
        cur_req = "R6";
        chk("R6 bit7 clears", ctl_rdata, 8'h03);
        @(negedge clk);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule